// File: doc/BRIEF.md
# Read-Latency Output Pipeline for a 32-bit SDRAM Model

This block is the device-side read return path of a synchronous DRAM model. The burst engine hands it at most one read word per clock. The block holds each word for the programmed read latency of 2 or 3 clocks and then presents it on the data bus, with one drive-enable per byte lane. Four byte masks gate the lane drivers after a fixed two-clock delay. The mask delay does not depend on the read latency.

A stop strobe marks a precharge or burst stop. On that edge it blocks the word being offered. It also blocks every later word that does not open a new burst, so the bus floats a latency's worth of clocks after the stop. Words that were already inside the pipeline still come out in order. A new burst may start on any cycle, even in the middle of another burst. The words of the older burst that are already queued drain ahead of the new ones, with no bubble between them. A latency code outside the two legal values runs the pipeline at latency 3 and sets a sticky error flag.

Top module: `rdp_read_path`

## Requirements
- R1: The 3-bit latency code selects latency 2 for 3'b010 and latency 3 for 3'b011. Every other code selects latency 3.
- R2: A word accepted at clock edge k is shown with `dq_valid` high during the cycle that follows edge k+L-1, where L is the latency selected at edge k. Words come out in the order they were accepted.
- R3: Words accepted on consecutive edges come out on consecutive cycles. A `rd_start` in the middle of a burst lets the already-queued words finish first, with no idle cycle in between.
- R4: Byte mask bit n covers `dq_out` bits 8n+7 down to 8n. A mask bit sampled high at edge m drives `dq_oe[n]` low in the cycle after edge m+1. This two-clock delay is the same at either latency.
- R5: Each byte lane of `dq_out` carries the output word's byte while its `dq_oe` bit is high, and is zero otherwise.
- R6: A word offered on an edge where `stop_strobe` is high is discarded. Until an edge with `rd_start` high and `stop_strobe` low, any offered word without `rd_start` is also discarded. Words accepted before the stop still come out.
- R7: `lat_err` goes high in the cycle after an edge that sampled a reserved latency code. It stays high until reset.
- R8: During and right after reset, `dq_valid`, `dq_oe` and `lat_err` are low. `dq_oe` is all zero whenever `dq_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lat_code | input | 3 | Read latency code (010: 2 clocks, 011: 3 clocks) |
| rd_valid | input | 1 | A read word is offered this cycle |
| rd_start | input | 1 | The offered word opens a new burst |
| rd_data | input | 32 | Offered read word |
| byte_mask | input | 4 | Per-lane output mask, bit n for byte n |
| stop_strobe | input | 1 | Precharge or burst stop seen this cycle |
| dq_out | output | 32 | Read data bus, masked lanes zero |
| dq_oe | output | 4 | Per-lane drive enable |
| dq_valid | output | 1 | A word is present at the output stage |
| lat_err | output | 1 | Sticky reserved-latency-code flag |

## Verification
The hardest state to reach is a stop that arrives while words are still in flight, followed by a burst engine that keeps offering words without starting a new burst. The bench must then show that the in-flight words appear, that the later words vanish, and that a fresh start restores the flow. A second hard case is a new burst that starts while the old one is still draining. Directed sequences set up both cases at each latency. The random phase then mixes stops, starts and mask changes across segments at both latencies, and each latency change follows an idle gap long enough for the pipeline to drain.

// File: rtl/rdp_pkg.sv
`timescale 1ns/1ps
package rdp_pkg;
  localparam logic [2:0] LAT_CODE_TWO   = 3'b010;
  localparam logic [2:0] LAT_CODE_THREE = 3'b011;
  localparam int unsigned MAX_LAT = 3;
  localparam int unsigned MIN_LAT = 2;

  // latency chosen for a code; reserved codes fall back to the longest
  function automatic logic [1:0] lat_from_code(input logic [2:0] code);
    return (code == LAT_CODE_TWO) ? 2'd2 : 2'd3;
  endfunction

  function automatic logic code_is_reserved(input logic [2:0] code);
    return !((code == LAT_CODE_TWO) || (code == LAT_CODE_THREE));
  endfunction

  // pipeline stage that receives a new word for a given latency
  function automatic int insert_stage(input int depth, input logic [1:0] lat);
    return depth - int'(lat);
  endfunction
endpackage

// File: rtl/rdp_lat_decode.sv
`timescale 1ns/1ps
module rdp_lat_decode
  import rdp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] lat_code,
  output logic [1:0] lat_sel,
  output logic       lat_err
);
  logic reserved_now;

  assign lat_sel      = lat_from_code(lat_code);
  assign reserved_now = code_is_reserved(lat_code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_err <= 1'b0;
    else if (reserved_now) lat_err <= 1'b1;
  end
endmodule

// File: rtl/rdp_entry_gate.sv
`timescale 1ns/1ps
module rdp_entry_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_valid,
  input  logic rd_start,
  input  logic stop_strobe,
  output logic accept
);
  logic halted;

  assign accept = rd_valid && !stop_strobe && (rd_start || !halted);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          halted <= 1'b0;
    else if (stop_strobe) halted <= 1'b1;
    else if (rd_start)    halted <= 1'b0;
  end
endmodule

// File: rtl/rdp_stage_pipe.sv
`timescale 1ns/1ps
module rdp_stage_pipe
  import rdp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = MAX_LAT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [DATA_W-1:0] din,
  input  logic [1:0]        lat_sel,
  output logic              out_vld,
  output logic [DATA_W-1:0] out_data
);
  logic [DEPTH-1:0]  vld_q;
  logic [DATA_W-1:0] data_q [DEPTH];
  int ins_idx;

  assign ins_idx = insert_stage(DEPTH, lat_sel);

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    logic              prev_vld;
    logic [DATA_W-1:0] prev_data;
    if (g == 0) begin : g_head
      assign prev_vld  = 1'b0;
      assign prev_data = '0;
    end else begin : g_body
      assign prev_vld  = vld_q[g-1];
      assign prev_data = data_q[g-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[g]  <= 1'b0;
        data_q[g] <= '0;
      end else if (accept && (ins_idx == g)) begin
        vld_q[g]  <= 1'b1;
        data_q[g] <= din;
      end else begin
        vld_q[g]  <= prev_vld;
        data_q[g] <= prev_data;
      end
    end
  end

  assign out_vld  = vld_q[DEPTH-1];
  assign out_data = data_q[DEPTH-1];
endmodule

// File: rtl/rdp_mask_delay.sv
`timescale 1ns/1ps
module rdp_mask_delay #(
  parameter int LANES = 4,
  parameter int DLY   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] mask_in,
  output logic [LANES-1:0] mask_out
);
  logic [LANES-1:0] tap_q [DLY];

  for (genvar g = 0; g < DLY; g++) begin : g_tap
    logic [LANES-1:0] src;
    if (g == 0) begin : g_first
      assign src = mask_in;
    end else begin : g_next
      assign src = tap_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tap_q[g] <= '0;
      else        tap_q[g] <= src;
    end
  end

  assign mask_out = tap_q[DLY-1];
endmodule

// File: rtl/rdp_read_path.sv
`timescale 1ns/1ps
module rdp_read_path
  import rdp_pkg::*;
#(
  parameter int LANE_W   = 8,
  parameter int LANES    = 4,
  parameter int MASK_DLY = 2,
  localparam int DATA_W  = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        lat_code,
  input  logic              rd_valid,
  input  logic              rd_start,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [LANES-1:0]  byte_mask,
  input  logic              stop_strobe,
  output logic [DATA_W-1:0] dq_out,
  output logic [LANES-1:0]  dq_oe,
  output logic              dq_valid,
  output logic              lat_err
);
  logic [1:0]        lat_sel;
  logic              accept;
  logic              pipe_vld;
  logic [DATA_W-1:0] pipe_data;
  logic [LANES-1:0]  lane_mask;

  rdp_lat_decode u_dec (
    .clk(clk), .rst_n(rst_n), .lat_code(lat_code),
    .lat_sel(lat_sel), .lat_err(lat_err)
  );

  rdp_entry_gate u_gate (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_start(rd_start),
    .stop_strobe(stop_strobe), .accept(accept)
  );

  rdp_stage_pipe #(.DATA_W(DATA_W), .DEPTH(MAX_LAT)) u_pipe (
    .clk(clk), .rst_n(rst_n), .accept(accept), .din(rd_data),
    .lat_sel(lat_sel), .out_vld(pipe_vld), .out_data(pipe_data)
  );

  rdp_mask_delay #(.LANES(LANES), .DLY(MASK_DLY)) u_mask (
    .clk(clk), .rst_n(rst_n), .mask_in(byte_mask), .mask_out(lane_mask)
  );

  assign dq_valid = pipe_vld;
  assign dq_oe    = {LANES{pipe_vld}} & ~lane_mask;

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign dq_out[b*LANE_W +: LANE_W] = pipe_data[b*LANE_W +: LANE_W] & {LANE_W{dq_oe[b]}};
  end
endmodule

// File: rtl/rdp_read_path_chk.sv
`timescale 1ns/1ps
module rdp_read_path_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       lat_code,
  input logic             rd_valid,
  input logic             stop_strobe,
  input logic [LANES-1:0] byte_mask,
  input logic             dq_valid,
  input logic [LANES-1:0] dq_oe,
  input logic             lat_err
);
  logic [1:0] since;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           since <= 2'd0;
    else if (since != 2'd3) since <= since + 2'd1;
  end

  p_oe_needs_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_valid |-> (dq_oe == '0));

  p_mask_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (since >= 2'd2) |-> (($past(byte_mask, 2) & dq_oe) == '0));

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (since != 2'd0 && $past(lat_err)) |-> lat_err);

  p_err_reserved_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (since != 2'd0 && $past(lat_code) != 3'b010 && $past(lat_code) != 3'b011) |-> lat_err);

  p_lat2_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (since == 2'd3 && dq_valid && $past(lat_code, 1) == 3'b010 &&
     $past(lat_code, 2) == 3'b010 && $past(lat_code, 3) == 3'b010)
    |-> ($past(rd_valid, 2) && !$past(stop_strobe, 2)));

  p_stop_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (since == 2'd3 && dq_valid && $past(lat_code, 2) == 3'b011 &&
     $past(lat_code, 3) == 3'b011)
    |-> ($past(rd_valid, 3) && !$past(stop_strobe, 3)));
endmodule

bind rdp_read_path rdp_read_path_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .lat_code(lat_code), .rd_valid(rd_valid),
  .stop_strobe(stop_strobe), .byte_mask(byte_mask), .dq_valid(dq_valid),
  .dq_oe(dq_oe), .lat_err(lat_err)
);

// File: tb/sim_rdp_read_path.sv
`timescale 1ns/1ps
module sim_rdp_read_path;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  lat_code;
  logic        rd_valid, rd_start, stop_strobe;
  logic [31:0] rd_data;
  logic [3:0]  byte_mask;
  logic [31:0] dq_out;
  logic [3:0]  dq_oe;
  logic        dq_valid, lat_err;

  always #5 clk = ~clk;

  rdp_read_path u0 (.*);

  localparam int NMAX = 4096;
  int checks = 0, errors = 0, n = 0;
  bit done = 0;
  bit halted_m = 0, err_m = 0;
  string cur_req = "R2";
  bit          acc_v  [NMAX];
  logic [31:0] acc_d  [NMAX];
  int          acc_l  [NMAX];
  logic [3:0]  mask_at[NMAX];
  logic [2:0]  code_now = 3'b011;

  function automatic int ref_lat(input logic [2:0] c);
    if (c == 3'b010) return 2;
    return 3;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h (step %0d)", req, what, act, exp, n);
    end
  endtask

  task automatic step(input bit v, input bit s, input bit st, input logic [31:0] d, input logic [3:0] m);
    bit ev;
    logic [31:0] ed, edq;
    logic [3:0] eoe;
    rd_valid = v; rd_start = s; stop_strobe = st; rd_data = d; byte_mask = m; lat_code = code_now;
    n++;
    acc_v[n]   = v && !st && (s || !halted_m);
    acc_d[n]   = d;
    acc_l[n]   = ref_lat(code_now);
    mask_at[n] = m;
    if (st) halted_m = 1; else if (s) halted_m = 0;
    if (code_now != 3'b010 && code_now != 3'b011) err_m = 1;
    @(posedge clk);
    @(negedge clk);
    ev = 0; ed = '0;
    if (acc_v[n-1] && acc_l[n-1] == 2) begin ev = 1; ed = acc_d[n-1]; end
    if (n >= 2 && acc_v[n-2] && acc_l[n-2] == 3) begin ev = 1; ed = acc_d[n-2]; end
    eoe = ev ? ~mask_at[n-1] : 4'h0;
    for (int b = 0; b < 4; b++) edq[b*8 +: 8] = eoe[b] ? ed[b*8 +: 8] : 8'h00;
    chk(cur_req, "dq_valid", {31'b0, dq_valid}, {31'b0, ev});
    chk("R4", "dq_oe", {28'b0, dq_oe}, {28'b0, eoe});
    chk("R5", "dq_out", dq_out, edq);
    chk("R7", "lat_err", {31'b0, lat_err}, {31'b0, err_m});
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) step(0, 0, 0, 32'h0, 4'h0);
  endtask

  task automatic burst(input int len, input logic [31:0] base, input logic [3:0] m);
    for (int i = 0; i < len; i++) step(1, i == 0, 0, base + 32'h01010101 * i, m);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NMAX; i++) begin acc_v[i] = 0; acc_d[i] = '0; acc_l[i] = 3; mask_at[i] = '0; end
    void'($urandom(32'd2024));
    rst_n = 0; lat_code = 3'b011; rd_valid = 0; rd_start = 0; stop_strobe = 0;
    rd_data = '0; byte_mask = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: state held by reset
    chk("R8", "reset dq_valid", {31'b0, dq_valid}, 32'h0);
    chk("R8", "reset dq_oe", {28'b0, dq_oe}, 32'h0);
    chk("R8", "reset lat_err", {31'b0, lat_err}, 32'h0);
    rst_n = 1;

    // R2, R1: latency 3 then latency 2
    cur_req = "R2"; code_now = 3'b011; burst(4, 32'hA0A1A2A3, 4'h0); idle(4);
    cur_req = "R1"; code_now = 3'b010; burst(4, 32'hB0B1B2B3, 4'h0); idle(4);
    // R4: mask delay at both latencies
    cur_req = "R4";
    for (int i = 0; i < 6; i++) step(1, i == 0, 0, 32'hC0C0C0C0 + i, 4'(i * 5));
    idle(4);
    code_now = 3'b011;
    for (int i = 0; i < 6; i++) step(1, i == 0, 0, 32'hD0D0D0D0 + i, 4'(15 - i * 3));
    idle(4);
    // R3: new burst while the old one drains
    cur_req = "R3";
    step(1, 1, 0, 32'h11111111, 0); step(1, 0, 0, 32'h22222222, 0);
    step(1, 1, 0, 32'h33333333, 0); step(1, 0, 0, 32'h44444444, 0); idle(4);
    code_now = 3'b010;
    step(1, 1, 0, 32'h55555555, 0); step(1, 1, 0, 32'h66666666, 0); idle(4);
    // R6: stop mid-burst, further words without start dropped, restart
    cur_req = "R6";
    for (int lc = 0; lc < 2; lc++) begin
      code_now = lc == 0 ? 3'b010 : 3'b011;
      step(1, 1, 0, 32'h70000001, 0); step(1, 0, 0, 32'h70000002, 0);
      step(1, 0, 1, 32'h70000003, 0); step(1, 0, 0, 32'h70000004, 0);
      step(1, 0, 0, 32'h70000005, 0); step(0, 0, 0, 0, 0);
      step(1, 1, 1, 32'h70000006, 0); step(1, 0, 0, 32'h70000007, 0);
      step(1, 1, 0, 32'h70000008, 0); step(1, 0, 0, 32'h70000009, 0);
      idle(4);
    end
    // R1, R7: reserved code behaves as latency 3 and latches the error
    cur_req = "R1"; code_now = 3'b110; burst(3, 32'hE0E1E2E3, 4'h0); idle(4);
    code_now = 3'b011; burst(2, 32'hF0F1F2F3, 4'h0); idle(4);

    // random segments
    cur_req = "R2";
    for (int seg = 0; seg < 30; seg++) begin
      int len;
      case ($urandom % 4)
        0: code_now = 3'b010;
        1: code_now = 3'b011;
        2: code_now = 3'b000;
        default: code_now = 3'b111;
      endcase
      len = 20 + ($urandom % 40);
      for (int i = 0; i < len; i++) begin
        bit v, s, st;
        v  = ($urandom % 4) != 0;
        s  = ($urandom % 10) == 0;
        st = ($urandom % 12) == 0;
        step(v, s, st, $urandom, (($urandom % 10) < 3) ? 4'($urandom) : 4'h0);
      end
      idle(4);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule